// File: doc/BRIEF.md
# SPI EEPROM page-write controller

This block is an SPI master that serves byte-range requests for a serial EEPROM. A host presents an offset, a length and a read/write flag for one cycle. It then either collects the data bytes the controller streams out, or supplies bytes one at a time as the controller asks for them. When the request is finished, the controller pulses `done` together with an error code.

A read goes out as a single chip-select frame. A write is split at page boundaries. Each piece gets its own write-enable frame and its own program frame. After each program frame the controller reads the device status repeatedly until the device reports that it is ready. This polling has a cycle-counted timeout and a minimum number of reads. Parameters set the array size, the page size, the number of address bytes, the SCK rate, the timeout and whether the part is a 9-bit-address device.

When reset is released, the controller reads the device status once and reports whether the device is present.

Top module: `eeprom_page_ctl`

## Requirements
- R1: A request whose offset is at or above MEM_BYTES finishes with `done` and `err` = 1 (range), and no SPI frame is sent.
- R2: A request with zero length finishes with `done` and `err` = 1, and no SPI frame is sent.
- R3: A request that would run past the last byte of the array is shortened so that it ends on that byte. No data beyond the end is read or written.
- R4: A read is one frame: instruction 0x03, then the address most significant byte first, then one clocked-in byte per requested byte. Each received byte appears on `rd_data` with a one-cycle `rd_valid`, in address order.
- R5: A write is sent in segments. Each segment holds min(PAGE_BYTES − offset mod PAGE_BYTES, bytes still to send) bytes. One `wr_pop` pulse consumes one `wr_data` byte.
- R6: Each write segment is preceded by its own frame holding only 0x06. The segment frame is 0x02, then the address, then the data.
- R7: After each segment, the controller sends status frames (0x05 plus one read byte) until bit 0 of the status is clear. It then starts the next segment, or finishes with `err` = 0.
- R8: If bit 0 stays set, the controller stops once it has made at least MIN_POLLS status reads and TIMEOUT_CYC clock cycles have passed since polling began. It then finishes with `err` = 2 (timeout).
- R9: When NINE_BIT is set, bit 3 of the read or program instruction is 1 exactly when the byte address of that frame is 256 or higher (0x0B / 0x0A).
- R10: After reset, the controller makes one status frame. `present` is 1 if bit 0 of the returned status was clear and 0 otherwise. `busy` stays high until this frame ends.
- R11: The bus runs in SPI mode 0: SCK idles low and is low whenever chip select falls. Between frames, chip select stays high for at least 2·SCK_HALF clock cycles.
- R12: `busy` is high whenever a request or the start-up check is in progress. A `req_valid` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_offset | input | OFFW | Starting byte offset |
| req_len | input | OFFW | Byte count |
| wr_data | input | 8 | Next write byte, consumed on `wr_pop` |
| wr_pop | output | 1 | Pulse: the current `wr_data` byte was taken |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| done | output | 1 | Pulse: request finished |
| err | output | 2 | Result code: 0 ok, 1 range, 2 timeout |
| busy | output | 1 | Controller not idle |
| present | output | 1 | Start-up status check found the device ready |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |

## Verification
The bench issues writes that straddle a page boundary and the 256-byte line. A controller with wrong segment arithmetic would send one long frame, which the device wraps within its page, or it would leave the high-address bit stuck for the whole write; in both cases the readback shows the error. Requests at the array edge, out of range and of zero length are checked. A missing clamp would read or write past the end, and a missing check would start a frame that should never exist. A device that never becomes ready is used to check that polling gives up with a timeout code instead of hanging. A request issued during a transfer is checked to leave memory untouched. The same stuck device at reset is used to check that `present` drops.

// File: rtl/eeprom_ctl_pkg.sv
package eeprom_ctl_pkg;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_RANGE   = 2'd1,
        ERR_TIMEOUT = 2'd2
    } err_e;

    localparam logic [7:0] CMD_WEN    = 8'h06;
    localparam logic [7:0] CMD_STATUS = 8'h05;
    localparam logic [7:0] CMD_READ   = 8'h03;
    localparam logic [7:0] CMD_PROG   = 8'h02;

    typedef enum logic [3:0] {
        ST_BOOT_CMD, ST_BOOT_RD, ST_IDLE, ST_WEN, ST_INSTR,
        ST_ADDR, ST_DATA, ST_POLL_CMD, ST_POLL_RD
    } ctl_state_e;

    typedef struct packed {
        logic       start;
        logic [7:0] tx;
        logic       last;
    } byte_req_t;

    function automatic logic [7:0] with_high_bit(input logic [7:0] op, input logic hi);
        return op | {4'b0000, hi, 3'b000};
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import eeprom_ctl_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  byte_req_t req,
    output logic      done,
    output logic [7:0] rx,
    output logic      sck,
    output logic      cs_n,
    output logic      mosi,
    input  logic      miso
);
    localparam int CW = $clog2(2 * SCK_HALF + 1) + 1;

    typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_GAP} sh_state_e;

    sh_state_e      st;
    logic [CW-1:0]  cnt;
    logic [2:0]     bitn;
    logic [7:0]     sh;
    logic           last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SH_IDLE; cs_n <= 1'b1; sck <= 1'b0; mosi <= 1'b0;
            cnt <= '0; bitn <= '0; sh <= '0; rx <= '0; done <= 1'b0; last_q <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: if (req.start) begin
                    st <= SH_RUN; cs_n <= 1'b0; sh <= req.tx; mosi <= req.tx[7];
                    last_q <= req.last; cnt <= '0; bitn <= '0;
                end
                SH_RUN: if (cnt == CW'(SCK_HALF - 1)) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            if (last_q) begin
                                cs_n <= 1'b1;
                                st   <= SH_GAP;
                            end else begin
                                st   <= SH_IDLE;
                                done <= 1'b1;
                            end
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                            mosi <= sh[6];
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
                SH_GAP: if (cnt == CW'(2 * SCK_HALF - 1)) begin
                    cnt <= '0; st <= SH_IDLE; done <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    // R11: clock only toggles inside a frame
    assert_sck_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
        sck |-> !cs_n);
    // R11: mode 0, clock low when select falls
    assert_select_fall_low_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sck);

endmodule

// File: rtl/eeprom_seg_plan.sv
module eeprom_seg_plan #(
    parameter int PAGE_BYTES = 16,
    parameter int LENW       = 10,
    localparam int PW        = $clog2(PAGE_BYTES)
) (
    input  logic [PW-1:0]   off_lo,
    input  logic [LENW-1:0] remaining,
    output logic [LENW-1:0] seg_len
);
    logic [LENW-1:0] room;

    always_comb begin
        room    = LENW'(PAGE_BYTES) - LENW'(off_lo);
        seg_len = (room < remaining) ? room : remaining;
    end
endmodule

// File: rtl/eeprom_page_ctl.sv
module eeprom_page_ctl
    import eeprom_ctl_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int ADDR_BYTES  = 1,
    parameter int NINE_BIT    = 1,
    parameter int SCK_HALF    = 2,
    parameter int TIMEOUT_CYC = 3000,
    parameter int MIN_POLLS   = 3,
    localparam int OFFW       = $clog2(MEM_BYTES) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [OFFW-1:0] req_offset,
    input  logic [OFFW-1:0] req_len,
    input  logic [7:0]      wr_data,
    output logic            wr_pop,
    output logic [7:0]      rd_data,
    output logic            rd_valid,
    output logic            done,
    output logic [1:0]      err,
    output logic            busy,
    output logic            present,
    output logic            sck,
    output logic            cs_n,
    output logic            mosi,
    input  logic            miso
);
    localparam int LENW   = OFFW;
    localparam int PW     = $clog2(PAGE_BYTES);
    localparam int TW     = $clog2(TIMEOUT_CYC + 1);
    localparam int PCW    = $clog2(MIN_POLLS + 1);
    localparam int AIW    = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int HI_LIM = 1 << (8 * ADDR_BYTES);

    ctl_state_e      st;
    byte_req_t       brq;
    logic            launched, op_wr, sh_done, hi_page;
    logic [7:0]      sh_rx, addr_b;
    logic [OFFW-1:0] cur_off;
    logic [LENW-1:0] tot_rem, seg_rem, seg_len, clen;
    logic [AIW-1:0]  aidx;
    logic [TW-1:0]   tmr;
    logic [PCW-1:0]  polls;
    logic [OFFW:0]   req_end;
    logic [31:0]     off_w;

    spi_byte_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst(rst), .req(brq), .done(sh_done), .rx(sh_rx),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    eeprom_seg_plan #(.PAGE_BYTES(PAGE_BYTES), .LENW(LENW)) u_plan (
        .off_lo(cur_off[PW-1:0]), .remaining(tot_rem), .seg_len(seg_len)
    );

    assign busy = (st != ST_IDLE);

    always_comb begin
        off_w   = 32'(cur_off);
        hi_page = (NINE_BIT != 0) && (off_w >= 32'(HI_LIM));
        addr_b  = 8'(off_w >> (8 * aidx));
        req_end = {1'b0, req_offset} + {1'b0, req_len};
        clen    = (req_end > (OFFW+1)'(MEM_BYTES)) ? (LENW'(MEM_BYTES) - req_offset) : req_len;
        brq     = '0;
        case (st)
            ST_BOOT_CMD, ST_POLL_CMD: begin brq.start = 1'b1; brq.tx = CMD_STATUS; end
            ST_BOOT_RD, ST_POLL_RD:   begin brq.start = 1'b1; brq.last = 1'b1; end
            ST_WEN:   begin brq.start = 1'b1; brq.tx = CMD_WEN; brq.last = 1'b1; end
            ST_INSTR: begin
                brq.start = 1'b1;
                brq.tx    = with_high_bit(op_wr ? CMD_PROG : CMD_READ, hi_page);
            end
            ST_ADDR:  begin brq.start = 1'b1; brq.tx = addr_b; end
            ST_DATA:  begin
                brq.start = 1'b1;
                brq.tx    = op_wr ? wr_data : 8'h00;
                brq.last  = (seg_rem == LENW'(1));
            end
            default: ;
        endcase
        brq.start = brq.start && !launched;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_BOOT_CMD; launched <= 1'b0; op_wr <= 1'b0;
            cur_off <= '0; tot_rem <= '0; seg_rem <= '0; aidx <= '0;
            tmr <= '0; polls <= '0; present <= 1'b0;
            done <= 1'b0; err <= ERR_NONE; rd_valid <= 1'b0; rd_data <= '0; wr_pop <= 1'b0;
        end else begin
            done <= 1'b0; rd_valid <= 1'b0; wr_pop <= 1'b0;
            if (brq.start) launched <= 1'b1;
            else if (sh_done) launched <= 1'b0;
            if ((st == ST_POLL_CMD || st == ST_POLL_RD) && tmr != TW'(TIMEOUT_CYC))
                tmr <= tmr + TW'(1);
            if (brq.start && st == ST_DATA && op_wr) wr_pop <= 1'b1;
            case (st)
                ST_IDLE: if (req_valid) begin
                    if (req_offset >= OFFW'(MEM_BYTES) || req_len == '0) begin
                        done <= 1'b1; err <= ERR_RANGE;
                    end else begin
                        cur_off <= req_offset; tot_rem <= clen; seg_rem <= clen;
                        op_wr <= req_write; st <= req_write ? ST_WEN : ST_INSTR;
                    end
                end
                default: if (sh_done) begin
                    case (st)
                        ST_BOOT_CMD: st <= ST_BOOT_RD;
                        ST_BOOT_RD:  begin present <= ~sh_rx[0]; st <= ST_IDLE; end
                        ST_WEN:      begin seg_rem <= seg_len; st <= ST_INSTR; end
                        ST_INSTR:    begin aidx <= AIW'(ADDR_BYTES - 1); st <= ST_ADDR; end
                        ST_ADDR:     if (aidx == '0) st <= ST_DATA; else aidx <= aidx - AIW'(1);
                        ST_DATA: begin
                            seg_rem <= seg_rem - LENW'(1);
                            tot_rem <= tot_rem - LENW'(1);
                            cur_off <= cur_off + OFFW'(1);
                            if (!op_wr) begin rd_valid <= 1'b1; rd_data <= sh_rx; end
                            if (seg_rem == LENW'(1)) begin
                                if (op_wr) begin
                                    st <= ST_POLL_CMD; tmr <= '0; polls <= '0;
                                end else begin
                                    st <= ST_IDLE; done <= 1'b1; err <= ERR_NONE;
                                end
                            end
                        end
                        ST_POLL_CMD: st <= ST_POLL_RD;
                        ST_POLL_RD: begin
                            if (polls != PCW'(MIN_POLLS)) polls <= polls + PCW'(1);
                            if (!sh_rx[0]) begin
                                if (tot_rem == '0) begin
                                    st <= ST_IDLE; done <= 1'b1; err <= ERR_NONE;
                                end else begin
                                    st <= ST_WEN;
                                end
                            end else if (polls >= PCW'(MIN_POLLS - 1) && tmr == TW'(TIMEOUT_CYC)) begin
                                st <= ST_IDLE; done <= 1'b1; err <= ERR_TIMEOUT;
                            end else begin
                                st <= ST_POLL_CMD;
                            end
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            endcase
        end
    end

    // R4: read bytes only come out of a read request
    assert_rd_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !op_wr);
    // R6: write bytes are only consumed by a write request
    assert_pop_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_pop |-> op_wr);
    // R5: a data phase never spans more than a page
    assert_seg_in_page_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && op_wr) |-> (seg_rem != '0 && seg_rem <= LENW'(PAGE_BYTES)));
    // R12: completion leaves the controller idle
    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R8: timeout only after the full window and the minimum poll count
    assert_timeout_window_R8: assert property (@(posedge clk) disable iff (rst)
        (done && err == ERR_TIMEOUT) |-> (tmr == TW'(TIMEOUT_CYC) && polls >= PCW'(MIN_POLLS)));

endmodule

// File: tb/test_eeprom_page_ctl.sv
module test_eeprom_page_ctl;
    localparam int MEM = 512;
    localparam int HALF = 2;
    localparam int TMO = 3000;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [9:0] req_offset = '0, req_len = '0;
    logic [7:0] wr_data, rd_data;
    logic wr_pop, rd_valid, done, busy, present, sck, cs_n, mosi, miso;
    logic [1:0] err;

    always #4 clk = ~clk;

    eeprom_page_ctl i_eeprom_page_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_len(req_len), .wr_data(wr_data), .wr_pop(wr_pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err), .busy(busy),
        .present(present), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int checks = 0, errors = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    // ---------------- device model ----------------
    logic [7:0] mem [0:MEM-1];
    logic [7:0] exp_mem [0:MEM-1];
    logic [7:0] sr = '0, instr = '0, out_byte = '0, last_instr = '0;
    logic [7:0] pbuf [0:15];
    logic [2:0] bitc = '0;
    int bytec = 0, wn = 0, maddr = 0, busy_left = 0;
    logic stuck = 1'b0, wel = 1'b0;
    int frames = 0, wren_frames = 0, stat_frames = 0, seg_n = 0;
    int seg_len_log [0:15];
    logic seg_hi_log [0:15];

    assign miso = cs_n ? 1'b0 : out_byte[3'd7 - bitc];

    always @(negedge cs_n) begin
        bitc = '0; bytec = 0; wn = 0; out_byte = '0;
    end

    always @(posedge sck) if (!cs_n) begin
        sr = {sr[6:0], mosi};
        if (bitc == 3'd7) begin
            bitc = '0;
            if (bytec == 0) begin
                instr = sr; out_byte = '0;
                if (sr == 8'h06) wel = 1'b1;
                if (sr == 8'h05) out_byte = {6'b0, wel, stuck || busy_left > 0};
            end else if (instr[2:0] == 3'b011) begin
                if (bytec == 1) maddr = {23'b0, instr[3], sr};
                out_byte = mem[maddr % MEM];
                maddr = maddr + 1;
            end else if (instr[2:0] == 3'b010) begin
                if (bytec == 1) maddr = {23'b0, instr[3], sr};
                else if (wn < 16) begin pbuf[wn] = sr; wn = wn + 1; end
            end
            bytec = bytec + 1;
        end else begin
            bitc = bitc + 3'd1;
        end
    end

    always @(posedge cs_n) if (bytec >= 1) begin
        frames = frames + 1;
        last_instr = instr;
        if (instr == 8'h06) wren_frames = wren_frames + 1;
        if (instr == 8'h05) begin
            stat_frames = stat_frames + 1;
            if (busy_left > 0) busy_left = busy_left - 1;
        end
        if (instr[2:0] == 3'b010 && instr[7:4] == 4'h0 && bytec >= 2) begin
            if (seg_n < 16) begin
                seg_len_log[seg_n] = wn; seg_hi_log[seg_n] = instr[3];
            end
            seg_n = seg_n + 1;
            if (wel) for (int i = 0; i < wn; i++)
                mem[(maddr & ~15) | ((maddr + i) & 15)] = pbuf[i];
            wel = 1'b0;
            busy_left = 2;
        end
    end

    // ---------------- host side ----------------
    logic [7:0] wsrc [0:63];
    logic [5:0] wptr = '0;
    assign wr_data = wsrc[wptr];
    always @(posedge clk) if (wr_pop) wptr <= wptr + 6'd1;

    logic [7:0] expq [$];
    int done_cnt = 0, rd_cnt = 0;
    logic [1:0] last_err = '0;
    string cur_tag = "R4";

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_cnt++;
            if (expq.size() == 0) chk(1'b0, cur_tag, int'(rd_data), -1);
            else begin
                logic [7:0] e;
                e = expq.pop_front();
                chk(rd_data == e, cur_tag, int'(rd_data), int'(e));
            end
        end
        if (done) begin done_cnt++; last_err = err; end
    end

    // chip-select gap and mode-0 monitor
    int hi_cnt = 1000, gap_bad = 0;
    logic cs_prev = 1'b1;
    always @(negedge clk) begin
        if (cs_prev && !cs_n) begin
            if (hi_cnt < 2 * HALF) gap_bad++;
            if (sck) gap_bad++;
            hi_cnt = 0;
        end
        if (cs_n) hi_cnt++;
        cs_prev = cs_n;
    end

    task automatic send_req(input bit wr, input int off, input int len);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_offset = 10'(off); req_len = 10'(len);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_req(input bit wr, input int off, input int len);
        int d0;
        d0 = done_cnt;
        send_req(wr, off, len);
        while (done_cnt == d0) @(negedge clk);
    endtask

    task automatic do_read(input int off, input int len, input string tag);
        int n;
        cur_tag = tag;
        n = (off + len > MEM) ? MEM - off : len;
        for (int i = 0; i < n; i++) expq.push_back(exp_mem[off + i]);
        run_req(1'b0, off, len);
        chk(expq.size() == 0, tag, expq.size(), 0);
    endtask

    task automatic do_write(input int off, input int len, input int seed);
        int n;
        n = (off + len > MEM) ? MEM - off : len;
        for (int i = 0; i < 64; i++) wsrc[i] = 8'((seed + i * 11) & 255);
        wptr = '0;
        for (int i = 0; i < n; i++) exp_mem[off + i] = wsrc[i];
        run_req(1'b1, off, len);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int f0, w0, s0, r0, d0, t0;
        for (int i = 0; i < MEM; i++) begin mem[i] = pat(i); exp_mem[i] = pat(i); end
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0, "R11 reset bus idle", int'({cs_n, sck}), 2);
        chk(busy == 1'b1, "R10 busy during reset", int'(busy), 1);
        rst = 1'b0;
        while (busy) @(negedge clk);
        chk(present == 1'b1, "R10 present", int'(present), 1);
        chk(stat_frames == 1, "R10 one status read", stat_frames, 1);

        // R4 plain read
        f0 = frames; r0 = rd_cnt;
        do_read(10, 5, "R4");
        chk(frames == f0 + 1, "R4 single frame", frames - f0, 1);
        chk(last_instr == 8'h03, "R4 read instruction", int'(last_instr), 3);
        chk(rd_cnt == r0 + 5 && last_err == 2'd0, "R4 count", rd_cnt - r0, 5);

        // R9 upper half read
        do_read(300, 4, "R9");
        chk(last_instr == 8'h0B, "R9 read high bit", int'(last_instr), 11);

        // R5 R6 R7 page-split write
        w0 = wren_frames; s0 = seg_n;
        do_write(10, 20, 3);
        chk(seg_n == s0 + 2, "R5 segment count", seg_n - s0, 2);
        chk(seg_len_log[s0] == 6 && seg_len_log[s0 + 1] == 14, "R5 segment sizes",
            seg_len_log[s0] * 100 + seg_len_log[s0 + 1], 614);
        chk(wren_frames == w0 + 2, "R6 enable per segment", wren_frames - w0, 2);
        chk(last_err == 2'd0, "R7 write ok", int'(last_err), 0);
        do_read(10, 20, "R7 readback");

        // R9 write across 256
        s0 = seg_n;
        do_write(250, 10, 77);
        chk(seg_len_log[s0] == 6 && seg_len_log[s0 + 1] == 4, "R9 split sizes",
            seg_len_log[s0] * 100 + seg_len_log[s0 + 1], 604);
        chk(seg_hi_log[s0] == 1'b0 && seg_hi_log[s0 + 1] == 1'b1, "R9 program high bit",
            int'({seg_hi_log[s0], seg_hi_log[s0 + 1]}), 1);
        do_read(248, 16, "R9 readback");

        // R1 R2 rejects
        f0 = frames;
        run_req(1'b0, 512, 3);
        chk(last_err == 2'd1, "R1 range err", int'(last_err), 1);
        run_req(1'b1, 5, 0);
        chk(last_err == 2'd1, "R2 zero len err", int'(last_err), 1);
        repeat (20) @(negedge clk);
        chk(frames == f0, "R1 R2 no frames", frames - f0, 0);

        // R3 clamps
        r0 = rd_cnt;
        do_read(508, 10, "R3");
        chk(rd_cnt == r0 + 4, "R3 read clamp", rd_cnt - r0, 4);
        s0 = seg_n;
        do_write(510, 5, 200);
        chk(seg_len_log[s0] == 2, "R3 write clamp", seg_len_log[s0], 2);
        do_read(0, 2, "R3 start untouched");

        // R12 request during busy is ignored
        d0 = done_cnt;
        cur_tag = "R12";
        for (int i = 0; i < 8; i++) expq.push_back(exp_mem[i]);
        send_req(1'b0, 0, 8);
        repeat (10) @(negedge clk);
        wsrc[0] = 8'hEE; wptr = '0;
        send_req(1'b1, 100, 1);
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(done_cnt == d0 + 1, "R12 one completion", done_cnt - d0, 1);
        do_read(100, 1, "R12 memory untouched");

        // R8 timeout
        stuck = 1'b1;
        s0 = stat_frames; t0 = 0;
        begin
            int dd;
            dd = done_cnt;
            for (int i = 0; i < 64; i++) wsrc[i] = 8'h5A;
            wptr = '0; exp_mem[40] = 8'h5A;
            send_req(1'b1, 40, 1);
            while (done_cnt == dd) begin @(negedge clk); t0++; end
        end
        chk(last_err == 2'd2, "R8 timeout code", int'(last_err), 2);
        chk(stat_frames - s0 >= 3, "R8 minimum polls", stat_frames - s0, 3);
        chk(t0 >= TMO, "R8 window", t0, TMO);

        chk(gap_bad == 0, "R11 select gap and mode", gap_bad, 0);

        // R10 absent device at start-up
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk); rst = 1'b0;
        while (busy) @(negedge clk);
        chk(present == 1'b0, "R10 not present", int'(present), 0);
        stuck = 1'b0;

        finish_run();
    end
endmodule